// File: doc/BRIEF.md
# Disk Controller Mode Register

This block is the host-facing control core of an integrated floppy controller. The host CPU touches sixteen consecutive addresses. Each address sets or clears one soft switch: address bits 3:1 pick the switch and address bit 0 is its new value. Three of those switches belong to this block: the drive motor, the shift/load select and the read/write select. The other five indices (the stepper phases and the drive selector) are handled elsewhere and leave this block untouched.

The shift/load and read/write selects double as the access path to a five-bit mode register. When both selects are set and the motor is off, a write access loads the low five data bits into the mode register. When shift/load is set and read/write is clear, a read access returns the mode bits together with the motor state. The mode bits drive the controller's configuration outputs: latched data, asynchronous operation, motor-off-delay disable and fast bit cells. Value 0x00 gives the legacy 5.25-inch setup. Value 0x07 gives slow cells with the other three features on, and value 0x0F gives the 3.5-inch setup with fast cells.

A cell-period strobe generator shows the effect of the fast-cell bit. Its clock stands for a 7 MHz reference, so a period of 28 clocks equals a 4 µs cell and a period of 14 clocks equals a 2 µs cell. At the fast rate a byte passes through the data path every 16 host cycles at 1 MHz.

Top module: `disk_mode_ctrl`

## Requirements
- R1: After a synchronous reset, the mode bits, all three switches, rdata and every configuration output are 0.
- R2: A valid access updates one switch one cycle later. The switch index is acc_addr[3:1]: 4 is the motor, 6 is shift/load and 7 is read/write. The new value is acc_addr[0]. An access to any other index leaves all three switches unchanged.
- R3: A write access loads wdata[4:0] into the mode bits, and the new value is visible one cycle later. This happens only if, with that access's own switch change applied, shift/load and read/write are both 1 and the motor is 0. wdata[7:5] are ignored.
- R4: A write access leaves the mode bits unchanged while the motor is on, or while either select is clear.
- R5: A read access captures into rdata one cycle later. If, with that access's switch change applied, shift/load is 1 and read/write is 0, rdata is {2'b00, motor, mode[4:0]}. In any other switch state rdata is 0x00. Without a read access, rdata holds its value.
- R6: The configuration outputs decode the mode bits as follows: latch_mode is bit 0, async_mode is bit 1, motor_delay_off is bit 2 and fast_cell is bit 3. 0x00 clears all four, 0x07 sets all but fast_cell, and 0x0F sets all four.
- R7: While the cell speed is steady, cell_strobe pulses every 28 clocks with slow cells and every 14 clocks with fast cells.
- R8: cell_strobe is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | 4 | Soft-switch address: bits 3:1 index, bit 0 value |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Captured status byte |
| mode_bits | output | 5 | Mode register contents |
| motor_on | output | 1 | Motor switch state |
| shift_load | output | 1 | Shift/load select state |
| read_write | output | 1 | Read/write select state |
| latch_mode | output | 1 | Latched data mode |
| async_mode | output | 1 | Asynchronous operation |
| motor_delay_off | output | 1 | Motor-off delay disabled |
| fast_cell | output | 1 | Fast (2 µs) bit cells |
| cell_strobe | output | 1 | One-clock pulse per bit cell |

## Verification
Every result that depends on an access (switch states, mode bits, configuration outputs and rdata) is due on the first clock edge after the access cycle. The bench drives each access for one cycle from a falling edge and samples at the next falling edge, just after that rising edge. Strobe spacing is measured in falling edges between consecutive pulses, and only after the first pulse following a mode change, because the timer restarts one cycle after the fast-cell bit changes. The exhaustive sweep writes all 256 data values and reads each one back through the status path.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  // switch indices on acc_addr[3:1]
  localparam int SW_MOTOR = 4;
  localparam int SW_SHIFT = 6;
  localparam int SW_RDWR  = 7;
  localparam int NUM_SW   = 3;
  // positions inside the switch vector
  localparam int V_MOTOR = 0;
  localparam int V_SHIFT = 1;
  localparam int V_RDWR  = 2;
  // mode bit positions
  localparam int MB_LATCH   = 0;
  localparam int MB_ASYNC   = 1;
  localparam int MB_NODELAY = 2;
  localparam int MB_FAST    = 3;
endpackage

// File: rtl/dmr_switches.sv
module dmr_switches
  import dmr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_SW-1:0] sw_q,
  output logic [NUM_SW-1:0] sw_nxt
);
  localparam int SEL_W = ADDR_W - 1;
  localparam int IDX [NUM_SW] = '{SW_MOTOR, SW_SHIFT, SW_RDWR};

  logic [SEL_W-1:0] sel;
  assign sel = acc_addr[ADDR_W-1:1];

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    always_comb begin
      if (acc_valid && sel == SEL_W'(IDX[g])) sw_nxt[g] = acc_addr[0];
      else                                    sw_nxt[g] = sw_q[g];
    end
    always_ff @(posedge clk) begin
      if (rst) sw_q[g] <= 1'b0;
      else     sw_q[g] <= sw_nxt[g];
    end
  end
endmodule

// File: rtl/dmr_mode_reg.sv
module dmr_mode_reg
  import dmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SW-1:0] sw_nxt,
  output logic [MODE_W-1:0] mode_q,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int PAD_W = DATA_W - MODE_W - 1;

  logic mode_sel, status_sel;
  assign mode_sel   = sw_nxt[V_SHIFT] && sw_nxt[V_RDWR] && !sw_nxt[V_MOTOR];
  assign status_sel = sw_nxt[V_SHIFT] && !sw_nxt[V_RDWR];

  logic [DATA_W-1:0] status_byte;
  assign status_byte = {{PAD_W{1'b0}}, sw_nxt[V_MOTOR], mode_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      rdata_q <= '0;
    end else if (acc_valid) begin
      if (acc_write) begin
        if (mode_sel) mode_q <= wdata[MODE_W-1:0];
      end else begin
        rdata_q <= status_sel ? status_byte : '0;
      end
    end
  end
endmodule

// File: rtl/dmr_cell_timer.sv
module dmr_cell_timer #(
  parameter int SLOW_DIV = 28,
  parameter int FAST_DIV = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic strobe
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             fast_d;

  assign last = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fast_d <= 1'b0;
      strobe <= 1'b0;
    end else begin
      fast_d <= fast;
      if (fast != fast_d) begin
        cnt    <= '0;
        strobe <= 1'b0;
      end else if (cnt == last) begin
        cnt    <= '0;
        strobe <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        strobe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/disk_mode_ctrl.sv
module disk_mode_ctrl
  import dmr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int MODE_W   = 5,
  parameter int SLOW_DIV = 28,
  parameter int FAST_DIV = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [MODE_W-1:0] mode_bits,
  output logic              motor_on,
  output logic              shift_load,
  output logic              read_write,
  output logic              latch_mode,
  output logic              async_mode,
  output logic              motor_delay_off,
  output logic              fast_cell,
  output logic              cell_strobe
);
  logic [NUM_SW-1:0] sw_q, sw_nxt;
  logic [MODE_W-1:0] mode_q;

  dmr_switches #(.ADDR_W(ADDR_W)) u_sw (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .sw_q(sw_q), .sw_nxt(sw_nxt)
  );

  dmr_mode_reg #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .wdata(wdata), .sw_nxt(sw_nxt), .mode_q(mode_q), .rdata_q(rdata)
  );

  dmr_cell_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
    .clk(clk), .rst(rst), .fast(mode_q[MB_FAST]), .strobe(cell_strobe)
  );

  assign mode_bits       = mode_q;
  assign motor_on        = sw_q[V_MOTOR];
  assign shift_load      = sw_q[V_SHIFT];
  assign read_write      = sw_q[V_RDWR];
  assign latch_mode      = mode_q[MB_LATCH];
  assign async_mode      = mode_q[MB_ASYNC];
  assign motor_delay_off = mode_q[MB_NODELAY];
  assign fast_cell       = mode_q[MB_FAST];
endmodule

// File: rtl/disk_mode_ctrl_chk.sv
module disk_mode_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int MODE_W   = 5,
  parameter int SLOW_DIV = 28,
  parameter int FAST_DIV = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [2:0]        acc_sel,
  input logic [MODE_W-1:0] wdata_lo,
  input logic [DATA_W-1:0] rdata,
  input logic [MODE_W-1:0] mode_bits,
  input logic              motor_on,
  input logic              shift_load,
  input logic              read_write,
  input logic              fast_cell,
  input logic              cell_strobe
);
  localparam int GAP_W = $clog2(SLOW_DIV + FAST_DIV) + 2;

  logic other_sel;
  assign other_sel = acc_sel != 3'd4 && acc_sel != 3'd6 && acc_sel != 3'd7;

  logic [GAP_W-1:0] gap;
  logic             seen, chg, fast_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; seen <= 1'b0; chg <= 1'b0; fast_prev <= 1'b0;
    end else begin
      fast_prev <= fast_cell;
      if (cell_strobe) begin
        gap  <= GAP_W'(1);
        seen <= 1'b1;
        chg  <= 1'b0;
      end else begin
        gap <= gap + 1'b1;
        chg <= chg | (fast_cell != fast_prev);
      end
    end
  end

  assert_switch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || other_sel) |=> $stable({motor_on, shift_load, read_write}));

  assert_mode_load_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && other_sel && shift_load && read_write && !motor_on)
    |=> mode_bits == $past(wdata_lo));

  assert_mode_guard_R4: assert property (@(posedge clk) disable iff (rst)
    ((acc_valid && other_sel && motor_on) || !acc_valid) |=> $stable(mode_bits));

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> $stable(rdata));

  assert_strobe_period_R7: assert property (@(posedge clk) disable iff (rst)
    (cell_strobe && seen && !chg && fast_cell == fast_prev)
    |-> gap == (fast_cell ? GAP_W'(FAST_DIV) : GAP_W'(SLOW_DIV)));

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (rst)
    cell_strobe |=> !cell_strobe);
endmodule

bind disk_mode_ctrl disk_mode_ctrl_chk #(
  .DATA_W(DATA_W), .MODE_W(MODE_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sel(acc_addr[3:1]), .wdata_lo(wdata[MODE_W-1:0]), .rdata(rdata),
  .mode_bits(mode_bits), .motor_on(motor_on), .shift_load(shift_load),
  .read_write(read_write), .fast_cell(fast_cell), .cell_strobe(cell_strobe)
);

// File: tb/test_disk_mode_ctrl.sv
module test_disk_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_valid, acc_write;
  logic [3:0] acc_addr;
  logic [7:0] wdata, rdata;
  logic [4:0] mode_bits;
  logic motor_on, shift_load, read_write;
  logic latch_mode, async_mode, motor_delay_off, fast_cell, cell_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disk_mode_ctrl i_disk_mode_ctrl (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .wdata(wdata), .rdata(rdata), .mode_bits(mode_bits),
    .motor_on(motor_on), .shift_load(shift_load), .read_write(read_write),
    .latch_mode(latch_mode), .async_mode(async_mode),
    .motor_delay_off(motor_delay_off), .fast_cell(fast_cell),
    .cell_strobe(cell_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one-cycle access; results are sampled at the following falling edge
  task automatic access(input logic [3:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic check_decode(input string req, input logic [4:0] m);
    check(req, {28'd0, fast_cell, motor_delay_off, async_mode, latch_mode},
          {28'd0, m[3], m[2], m[1], m[0]});
  endtask

  task automatic measure(input string req, input int exp);
    int n;
    n = 0;
    while (!cell_strobe && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
    check("R8 strobe one cycle wide", cell_strobe, 0);
    n = 1;
    while (!cell_strobe && n < 200) begin @(negedge clk); n++; end
    check(req, n, exp);
  endtask

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset outputs",
          {rdata, 3'd0, mode_bits, motor_on, shift_load, read_write, latch_mode,
           async_mode, motor_delay_off, fast_cell, cell_strobe}, 0);

    // R2 switch addressing
    access(4'hD, 1'b0, 8'h00);
    check("R2 shift_load set", {motor_on, shift_load, read_write}, 3'b010);
    access(4'hF, 1'b0, 8'h00);
    check("R2 read_write set", {motor_on, shift_load, read_write}, 3'b011);
    access(4'h9, 1'b0, 8'h00);
    check("R2 motor set", {motor_on, shift_load, read_write}, 3'b111);
    access(4'h8, 1'b0, 8'h00);
    check("R2 motor clear", {motor_on, shift_load, read_write}, 3'b011);
    for (int a = 0; a < 16; a++) begin
      if (a[3:1] != 3'd4 && a[3:1] != 3'd6 && a[3:1] != 3'd7) begin
        access(4'(a), 1'b0, 8'h00);
        check("R2 other index ignored", {motor_on, shift_load, read_write}, 3'b011);
      end
    end

    // R3/R5/R6 sweep over every write value
    for (int v = 0; v < 256; v++) begin
      access(4'hF, 1'b1, 8'(v));
      check("R3 mode load", mode_bits, v & 31);
      check_decode("R6 decode", 5'(v));
      access(4'hE, 1'b0, 8'h00);
      check("R5 status read", rdata, v & 31);
    end

    // R4 guards
    access(4'hF, 1'b1, 8'h15);
    access(4'h9, 1'b0, 8'h00);
    access(4'hF, 1'b1, 8'h0A);
    check("R4 motor on blocks write", mode_bits, 5'h15);
    access(4'hE, 1'b0, 8'h00);
    check("R5 status with motor", rdata, 8'h35);
    access(4'h8, 1'b0, 8'h00);
    access(4'hC, 1'b0, 8'h00);
    access(4'hF, 1'b1, 8'h0A);
    check("R4 shift_load clear blocks write", mode_bits, 5'h15);
    access(4'hD, 1'b0, 8'h00);
    access(4'hE, 1'b0, 8'h00);
    access(4'h0, 1'b1, 8'h0A);
    check("R4 read_write clear blocks write", mode_bits, 5'h15);

    // R5 non-status reads and hold
    access(4'hE, 1'b0, 8'h00);
    check("R5 status again", rdata, 8'h15);
    repeat (5) @(negedge clk);
    check("R5 rdata holds", rdata, 8'h15);
    access(4'hF, 1'b0, 8'h00);
    check("R5 both selects read zero", rdata, 8'h00);
    access(4'hC, 1'b0, 8'h00);
    check("R5 shift clear read zero", rdata, 8'h00);
    access(4'hD, 1'b0, 8'h00);
    access(4'hF, 1'b0, 8'h00);

    // R6 named configurations
    access(4'hF, 1'b1, 8'h07);
    check_decode("R6 value 07", 5'h07);
    access(4'hF, 1'b1, 8'h0F);
    check_decode("R6 value 0F", 5'h0F);
    access(4'hF, 1'b1, 8'h00);
    check_decode("R6 value 00", 5'h00);

    // R7 strobe spacing
    measure("R7 slow period", 28);
    measure("R7 slow period", 28);
    access(4'hF, 1'b1, 8'h08);
    measure("R7 fast period", 14);
    measure("R7 fast period", 14);
    access(4'hF, 1'b1, 8'h07);
    measure("R7 slow period after fast", 28);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule